// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control unit of a small 8-bit CPU. It decides when an interrupt is taken, saves the CPU context on the stack, and produces the handler start address. Requests from eight maskable hardware sources are latched as pending bits. The global mask bit gates them, and that bit is set while the block is in reset. A software trap strobe comes with the trap instruction and is taken whatever the mask holds. Interrupt entry only happens when the decoder reports an instruction boundary.

When an interrupt is taken, the block freezes the program counter, the X and A registers and the condition codes. It writes them one byte at a time through a stack port with an acknowledge handshake, and the stack pointer moves down by one for each byte. It then sets the mask and gives a one-cycle vector strobe carrying the address of the handler. A return strobe reads the same five bytes back in the opposite order. The block then shows the restored values for one cycle and clears the mask. Two combinational wake outputs serve the low-power modes: any request ends Wait, and only sources flagged for Halt end Halt.

Top module: `irq_entry_seq`

## Requirements
- R1: Out of reset the mask output is 1, the sequencer is idle (`busy` low), `sp_o` equals its reset value (0xFF by default) and no request is pending.
- R2: A maskable request that arrives while the mask is 1 is latched but not taken. It is taken at the first instruction boundary after the mask has been cleared.
- R3: Entry starts only in a cycle where `eoi` is high and the sequencer is idle. Without `eoi`, pending requests wait.
- R4: Entry writes five bytes to stack addresses that fall by one each time, starting at `sp_o`. The order is PC low, PC high, X, A, CC. One byte completes per cycle in which `stk_ack` is high. While `stk_ack` is low, the address, the data and `sp_o` hold.
- R5: The mask is set once the fifth byte has been saved. The vector strobe follows, and it is high only while the mask is 1.
- R6: For source k the vector address is VEC_BASE + 2*k. For the trap it is VEC_BASE + 2*NSRC. With the defaults, source k gives 0xFFE0 + 2k and the trap gives 0xFFF0.
- R7: A return strobe while idle reads five bytes from rising addresses `sp_o`+1 onward, in the order CC, A, X, PC high, PC low. It then raises `ret_valid` for one cycle with the restored PC, X, A and CC, and the mask is 0 from the following cycle.
- R8: When several unmasked requests are pending, the lowest source number is taken first. The pending bit of a source clears when its vector is issued.
- R9: A trap at a boundary is taken whether the mask is 0 or 1, and it wins over maskable requests pending at the same boundary. Those requests stay pending.
- R10: `wake_wait` is high whenever a request is arriving or pending. `wake_halt` is high only for sources flagged in HALT_MASK (sources 0 and 1 by default).
- R11: The CPU strobes `mask_set` and `mask_clr` change the mask while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Maskable request strobes, bit k for source k |
| trap_req | input | 1 | Software trap, sampled with `eoi` |
| eoi | input | 1 | End of instruction (boundary) |
| iret_req | input | 1 | Return-from-interrupt strobe |
| mask_set | input | 1 | CPU sets the mask |
| mask_clr | input | 1 | CPU clears the mask |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| stk_we | output | 1 | Stack write request |
| stk_re | output | 1 | Stack read request |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, valid with `stk_ack` |
| stk_ack | input | 1 | Stack access completes this cycle |
| sp_o | output | SP_W | Stack pointer |
| busy | output | 1 | Sequencer active, CPU stalled |
| mask_o | output | 1 | Global mask bit |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_addr | output | 16 | Handler vector address |
| ret_valid | output | 1 | One-cycle restore strobe |
| ret_pc | output | 16 | Restored program counter |
| ret_x | output | 8 | Restored X |
| ret_a | output | 8 | Restored A |
| ret_cc | output | 8 | Restored condition codes |
| wake_wait | output | 1 | Wake from Wait |
| wake_halt | output | 1 | Wake from Halt |

## Verification
The bench raises a request while the mask is set and expects no entry. A design that ignored the mask would start stack writes at once. It also clears the mask without a boundary and expects the request to stay pending, while a design that skipped the `eoi` check would enter mid-instruction. It nests a trap inside a masked handler and unwinds both levels. Wrong push order, a wrong stack pointer direction or a swapped restore order would then show up as mismatched addresses or restored values. It also raises two sources together, a trap together with a maskable source, and stalls the acknowledge. These expose a reversed priority, a trap that loses to a maskable source, a pending bit that is never cleared (the same handler would run twice), and a transfer that moves on during a stall.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_POP,
    ST_DONE
  } seq_state_t;

  localparam int CTX_BYTES = 5;
  localparam int CNT_W     = 3;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CTX_BYTES - 1);

  // Vector address of slot idx: two bytes per slot above the base.
  function automatic logic [15:0] vec_for(input logic [15:0] base, input int unsigned idx);
    return base + 16'(2 * idx);
  endfunction

  // Restore runs backwards through the save slots.
  function automatic logic [CNT_W-1:0] pop_slot(input logic [CNT_W-1:0] cnt);
    return CNT_LAST - cnt;
  endfunction

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int NSRC = 8,
  parameter int IDX_W = 3,
  parameter logic [NSRC-1:0] HALT_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             mask,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend,
  output logic             avail,
  output logic [IDX_W-1:0] win_idx,
  output logic             wake_wait,
  output logic             wake_halt
);

  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] live;

  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr_vec[g] = clr_valid && (clr_idx == IDX_W'(g));
  end

  // A request arriving in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | irq_req;
  end

  assign elig  = pend & {NSRC{~mask}};
  assign avail = |elig;

  // Fixed priority: the lowest source number wins.
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDX_W'(i);
    end
  end

  assign live      = pend | irq_req;
  assign wake_wait = |live;
  assign wake_halt = |(live & HALT_MASK);

endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic cpu_set,
  input  logic cpu_clr,
  input  logic hw_set,
  input  logic hw_clr,
  output logic mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask <= 1'b1;
    else if (hw_set)      mask <= 1'b1;
    else if (hw_clr)      mask <= 1'b0;
    else if (idle) begin
      if (cpu_set)        mask <= 1'b1;
      else if (cpu_clr)   mask <= 1'b0;
    end
  end

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int IDX_W = 3,
  parameter logic [SP_W-1:0] SP_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_trap,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             iret_req,
  input  logic [15:0]      pc_in,
  input  logic [7:0]       x_in,
  input  logic [7:0]       a_in,
  input  logic [7:0]       cc_in,
  input  logic [7:0]       stk_rdata,
  input  logic             stk_ack,
  output logic             stk_we,
  output logic             stk_re,
  output logic [SP_W-1:0]  stk_addr,
  output logic [7:0]       stk_wdata,
  output logic [SP_W-1:0]  sp,
  output logic             busy,
  output logic             vec_valid,
  output logic             vec_trap,
  output logic [IDX_W-1:0] vec_idx,
  output logic             save_done,
  output logic             ret_valid,
  output logic [15:0]      ret_pc,
  output logic [7:0]       ret_x,
  output logic [7:0]       ret_a,
  output logic [7:0]       ret_cc,
  output logic             push_fire,
  output logic             pop_fire
);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctx_q [CTX_BYTES];
  logic             iret_go;

  assign busy      = (state != ST_IDLE);
  assign iret_go   = (state == ST_IDLE) && !take && iret_req;
  assign stk_we    = (state == ST_PUSH);
  assign stk_re    = (state == ST_POP);
  assign stk_addr  = stk_re ? (sp + SP_W'(1)) : sp;
  assign stk_wdata = ctx_q[cnt];
  assign push_fire = stk_we && stk_ack;
  assign pop_fire  = stk_re && stk_ack;
  assign save_done = push_fire && (cnt == CNT_LAST);
  assign vec_valid = (state == ST_VEC);
  assign ret_valid = (state == ST_DONE);

  // Slot layout: 0 PC low, 1 PC high, 2 X, 3 A, 4 CC.
  assign ret_pc = {ctx_q[1], ctx_q[0]};
  assign ret_x  = ctx_q[2];
  assign ret_a  = ctx_q[3];
  assign ret_cc = ctx_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sp       <= SP_RST;
      vec_trap <= 1'b0;
      vec_idx  <= '0;
      for (int i = 0; i < CTX_BYTES; i++) ctx_q[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (take) begin
            ctx_q[0] <= pc_in[7:0];
            ctx_q[1] <= pc_in[15:8];
            ctx_q[2] <= x_in;
            ctx_q[3] <= a_in;
            ctx_q[4] <= cc_in;
            vec_trap <= take_trap;
            vec_idx  <= take_idx;
            state    <= ST_PUSH;
          end else if (iret_go) begin
            state <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (push_fire) begin
            sp <= sp - SP_W'(1);
            if (cnt == CNT_LAST) state <= ST_VEC;
            else                 cnt   <= cnt + CNT_W'(1);
          end
        end
        ST_VEC: state <= ST_IDLE;
        ST_POP: begin
          if (pop_fire) begin
            sp <= sp + SP_W'(1);
            ctx_q[pop_slot(cnt)] <= stk_rdata;
            if (cnt == CNT_LAST) state <= ST_DONE;
            else                 cnt   <= cnt + CNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_RST = '1,
  parameter logic [15:0] VEC_BASE = 16'hFFE0,
  parameter logic [NSRC-1:0] HALT_MASK = NSRC'(3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            trap_req,
  input  logic            eoi,
  input  logic            iret_req,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      x_in,
  input  logic [7:0]      a_in,
  input  logic [7:0]      cc_in,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SP_W-1:0] stk_addr,
  output logic [7:0]      stk_wdata,
  input  logic [7:0]      stk_rdata,
  input  logic            stk_ack,
  output logic [SP_W-1:0] sp_o,
  output logic            busy,
  output logic            mask_o,
  output logic            vec_valid,
  output logic [15:0]     vec_addr,
  output logic            ret_valid,
  output logic [15:0]     ret_pc,
  output logic [7:0]      ret_x,
  output logic [7:0]      ret_a,
  output logic [7:0]      ret_cc,
  output logic            wake_wait,
  output logic            wake_halt
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  // Named internal events, also watched by the checker.
  logic [NSRC-1:0]  pend;
  logic             avail;
  logic [IDX_W-1:0] win_idx;
  logic             take_evt;
  logic             vec_trap;
  logic [IDX_W-1:0] vec_idx;
  logic             save_done;
  logic             push_fire;
  logic             pop_fire;
  logic             clr_valid;

  assign take_evt  = eoi && !busy && (trap_req || avail);
  assign clr_valid = vec_valid && !vec_trap;

  irq_pend_arb #(
    .NSRC(NSRC), .IDX_W(IDX_W), .HALT_MASK(HALT_MASK)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask(mask_o),
    .clr_valid(clr_valid), .clr_idx(vec_idx), .pend(pend), .avail(avail),
    .win_idx(win_idx), .wake_wait(wake_wait), .wake_halt(wake_halt)
  );

  irq_mask_ctl u_mask (
    .clk(clk), .rst_n(rst_n), .idle(!busy), .cpu_set(mask_set),
    .cpu_clr(mask_clr), .hw_set(save_done), .hw_clr(ret_valid), .mask(mask_o)
  );

  ctx_stack_seq #(
    .SP_W(SP_W), .IDX_W(IDX_W), .SP_RST(SP_RST)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take_evt), .take_trap(trap_req),
    .take_idx(win_idx), .iret_req(iret_req), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .cc_in(cc_in), .stk_rdata(stk_rdata), .stk_ack(stk_ack),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .sp(sp_o), .busy(busy), .vec_valid(vec_valid),
    .vec_trap(vec_trap), .vec_idx(vec_idx), .save_done(save_done),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_x(ret_x), .ret_a(ret_a),
    .ret_cc(ret_cc), .push_fire(push_fire), .pop_fire(pop_fire)
  );

  assign vec_addr = vec_for(VEC_BASE, vec_trap ? NSRC : int'(unsigned'(vec_idx)));

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eoi,
  input logic            trap_req,
  input logic            busy,
  input logic            mask_o,
  input logic            stk_we,
  input logic            stk_re,
  input logic            stk_ack,
  input logic [SP_W-1:0] stk_addr,
  input logic [7:0]      stk_wdata,
  input logic [SP_W-1:0] sp_o,
  input logic            vec_valid,
  input logic            ret_valid,
  input logic            wake_wait,
  input logic            wake_halt,
  input logic            push_fire,
  input logic            pop_fire
);

  assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eoi) |=> !stk_we);

  assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mask_o && !trap_req) |=> !stk_we);

  assert_stall_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !stk_ack) |=> (stk_we && $stable(stk_addr) && $stable(stk_wdata) && $stable(sp_o)));

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (sp_o == $past(sp_o) - SP_W'(1)));

  assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (sp_o == $past(sp_o) + SP_W'(1)));

  assert_vec_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> mask_o);

  assert_ret_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !mask_o);

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_we, stk_re, vec_valid, ret_valid}));

  assert_halt_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_halt |-> wake_wait);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi(eoi), .trap_req(trap_req), .busy(busy),
  .mask_o(mask_o), .stk_we(stk_we), .stk_re(stk_re), .stk_ack(stk_ack),
  .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp_o(sp_o),
  .vec_valid(vec_valid), .ret_valid(ret_valid), .wake_wait(wake_wait),
  .wake_halt(wake_halt), .push_fire(push_fire), .pop_fire(pop_fire)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int SP_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            trap_req = 1'b0, eoi = 1'b0, iret_req = 1'b0;
  logic            mask_set = 1'b0, mask_clr = 1'b0;
  logic [15:0]     pc_in = '0;
  logic [7:0]      x_in = '0, a_in = '0, cc_in = '0;
  logic            stk_we, stk_re, stk_ack;
  logic [SP_W-1:0] stk_addr, sp_o;
  logic [7:0]      stk_wdata, stk_rdata;
  logic            busy, mask_o, vec_valid, ret_valid, wake_wait, wake_halt;
  logic [15:0]     vec_addr, ret_pc;
  logic [7:0]      ret_x, ret_a, ret_cc;
  logic            ack_en = 1'b1;

  logic [7:0] mem [256];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] wq[$];   // expected stack writes {addr,data}
  logic [15:0] vq[$];   // expected vectors
  logic [39:0] rq[$];   // expected restores {pc,x,a,cc}
  logic [39:0] ctx_stk[$];
  logic [7:0]  exp_sp = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
    .eoi(eoi), .iret_req(iret_req), .mask_set(mask_set), .mask_clr(mask_clr),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .stk_ack(stk_ack),
    .sp_o(sp_o), .busy(busy), .mask_o(mask_o), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_x(ret_x), .ret_a(ret_a), .ret_cc(ret_cc),
    .wake_wait(wake_wait), .wake_halt(wake_halt)
  );

  // Stack memory model
  always_comb stk_ack = (stk_we | stk_re) & ack_en;
  assign stk_rdata = mem[stk_addr];
  always @(posedge clk) if (stk_we && stk_ack) mem[stk_addr] <= stk_wdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (stk_we && stk_ack) begin
        if (wq.size() == 0) chk(1'b0, "R4 unexpected push", {stk_addr, stk_wdata}, 0);
        else begin
          logic [15:0] e;
          e = wq.pop_front();
          chk({stk_addr, stk_wdata} == e, "R4 push addr/data", {stk_addr, stk_wdata}, e);
        end
      end
      if (vec_valid) begin
        if (vq.size() == 0) chk(1'b0, "R6 unexpected vector", vec_addr, 0);
        else begin
          logic [15:0] e;
          e = vq.pop_front();
          chk(vec_addr == e, "R6 vector address", vec_addr, e);
          chk(mask_o == 1'b1, "R5 mask set at vector", mask_o, 1);
        end
      end
      if (ret_valid) begin
        if (rq.size() == 0) chk(1'b0, "R7 unexpected restore", ret_pc, 0);
        else begin
          logic [39:0] e;
          e = rq.pop_front();
          chk({ret_pc, ret_x, ret_a, ret_cc} == e, "R7 restored context",
              {ret_pc, ret_x, ret_a, ret_cc}, e);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_entry(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                              input logic [7:0] cc, input logic [15:0] vec);
    pc_in = pc; x_in = x; a_in = a; cc_in = cc;
    wq.push_back({exp_sp,          pc[7:0]});
    wq.push_back({exp_sp - 8'd1,   pc[15:8]});
    wq.push_back({exp_sp - 8'd2,   x});
    wq.push_back({exp_sp - 8'd3,   a});
    wq.push_back({exp_sp - 8'd4,   cc});
    exp_sp = exp_sp - 8'd5;
    vq.push_back(vec);
    ctx_stk.push_back({pc, x, a, cc});
  endtask

  task automatic expect_return();
    rq.push_back(ctx_stk.pop_back());
    exp_sp = exp_sp + 8'd5;
  endtask

  task automatic pulse_eoi(input bit trap);
    eoi = 1'b1; trap_req = trap;
    tick();
    eoi = 1'b0; trap_req = 1'b0;
  endtask

  task automatic pulse_irq(input logic [NSRC-1:0] bits);
    irq_req = bits;
    tick();
    irq_req = '0;
  endtask

  task automatic pulse_iret();
    iret_req = 1'b1;
    tick();
    iret_req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    tick();
    while (busy && n < 100) begin
      tick();
      n++;
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) tick();
    // R1 reset state
    chk(mask_o == 1'b1, "R1 mask after reset", mask_o, 1);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);
    chk(sp_o == 8'hFF, "R1 sp after reset", sp_o, 8'hFF);
    chk(wake_wait == 1'b0, "R1 nothing pending", wake_wait, 0);
    rst_n = 1'b1;
    tick();

    // R2/R10: masked request held, non-halt source
    pulse_irq(8'h10);
    chk(wake_wait == 1'b1, "R10 wake_wait on pending", wake_wait, 1);
    chk(wake_halt == 1'b0, "R10 no halt wake from source 4", wake_halt, 0);
    pulse_eoi(1'b0);
    tick();
    chk(busy == 1'b0, "R2 masked request not taken", busy, 0);
    chk(sp_o == 8'hFF, "R2 no push while masked", sp_o, 8'hFF);

    // R11: CPU clears mask; R3 no entry without eoi
    mask_clr = 1'b1; tick(); mask_clr = 1'b0;
    chk(mask_o == 1'b0, "R11 mask cleared by CPU", mask_o, 0);
    repeat (3) tick();
    chk(busy == 1'b0, "R3 no entry without boundary", busy, 0);

    // R2/R4/R5/R6: entry of source 4
    expect_entry(16'h1234, 8'h11, 8'h22, 8'h33, 16'hFFE8);
    pulse_eoi(1'b0);
    chk(busy == 1'b1, "R3 entry at boundary", busy, 1);
    wait_idle();
    chk(mask_o == 1'b1, "R5 mask set after entry", mask_o, 1);
    chk(sp_o == exp_sp, "R4 sp after entry", sp_o, exp_sp);
    chk(wake_wait == 1'b0, "R8 pending cleared at vector", wake_wait, 0);

    // R9: trap nested while masked
    expect_entry(16'hABCD, 8'h44, 8'h55, 8'h66, 16'hFFF0);
    pulse_eoi(1'b1);
    wait_idle();
    chk(sp_o == exp_sp, "R9 sp after trap entry", sp_o, exp_sp);

    // R7: unwind both levels
    expect_return();
    pulse_iret();
    wait_idle();
    tick();
    chk(mask_o == 1'b0, "R7 mask cleared after return", mask_o, 0);
    chk(sp_o == exp_sp, "R7 sp after return", sp_o, exp_sp);
    mask_set = 1'b1; tick(); mask_set = 1'b0;
    chk(mask_o == 1'b1, "R11 mask set by CPU", mask_o, 1);
    expect_return();
    pulse_iret();
    wait_idle();
    tick();
    chk(sp_o == 8'hFF, "R7 sp back at top", sp_o, 8'hFF);
    chk(mask_o == 1'b0, "R7 mask cleared after second return", mask_o, 0);

    // R8/R10: two sources at once, ack stall on the first entry
    pulse_irq(8'h22);
    chk(wake_halt == 1'b1, "R10 halt wake from source 1", wake_halt, 1);
    expect_entry(16'h0F00, 8'h01, 8'h02, 8'h03, 16'hFFE2);
    ack_en = 1'b0;
    pulse_eoi(1'b0);
    repeat (2) tick();
    chk(busy == 1'b1 && stk_we == 1'b1, "R4 waiting on ack", {busy, stk_we}, 2'b11);
    chk(sp_o == 8'hFF, "R4 sp held during stall", sp_o, 8'hFF);
    chk(stk_addr == 8'hFF, "R4 addr held during stall", stk_addr, 8'hFF);
    ack_en = 1'b1;
    wait_idle();
    expect_return();
    pulse_iret();
    wait_idle();
    tick();
    expect_entry(16'h0F80, 8'h07, 8'h08, 8'h09, 16'hFFEA);
    pulse_eoi(1'b0);
    wait_idle();
    expect_return();
    pulse_iret();
    wait_idle();
    tick();
    pulse_eoi(1'b0);
    tick();
    chk(busy == 1'b0, "R8 serviced source not retaken", busy, 0);

    // R9: trap beats maskable at the same boundary
    pulse_irq(8'h01);
    expect_entry(16'h2000, 8'hA1, 8'hA2, 8'hA3, 16'hFFF0);
    pulse_eoi(1'b1);
    wait_idle();
    chk(wake_wait == 1'b1, "R9 maskable still pending after trap", wake_wait, 1);
    expect_return();
    pulse_iret();
    wait_idle();
    tick();
    expect_entry(16'h3000, 8'hB1, 8'hB2, 8'hB3, 16'hFFE0);
    pulse_eoi(1'b0);
    wait_idle();
    expect_return();
    pulse_iret();
    wait_idle();
    repeat (2) tick();

    chk(wq.size() == 0, "R4 all pushes seen", wq.size(), 0);
    chk(vq.size() == 0, "R6 all vectors seen", vq.size(), 0);
    chk(rq.size() == 0, "R7 all restores seen", rq.size(), 0);
    chk(sp_o == 8'hFF, "R7 sp at top at end", sp_o, 8'hFF);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule